// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This peripheral keeps time as a 32-bit count of whole seconds and raises a single level interrupt when that count reaches a programmed alarm value. Software reaches it through a simple register bus with a select, a write strobe, a byte address and write data. Reads return data combinationally in the same cycle. A one-cycle-per-second enable input, produced elsewhere from a slow oscillator, advances the count. The counter runs at all times. Software can set it to any value, but it cannot stop it.

An alarm fires on an exact, wrapping comparison. The raw alarm flag is set whenever an event changes the count or the alarm value so that the two become equal. Events are a second tick, a write of the count preset or a write of the alarm value. The flag then stays set until software writes the clear location, whatever data that write carries. A one-bit mask gates the flag onto the interrupt pin. A read-only identification window sits in the last eight words of the 4 KB space.

Register word offsets: 0x00 live count (read-only), 0x04 alarm value, 0x08 count preset, 0x0C control (reads 1), 0x10 mask, 0x14 raw flag (read-only), 0x18 masked flag (read-only), 0x1C clear (write-only). Addresses that are not word-aligned, and addresses outside the low 4 KB, are unmapped.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset the count, alarm value, preset readback, mask and raw flag all read 0, and the interrupt pin is low.
- R2: Each cycle with the second tick high adds one to the count, and 0xFFFFFFFF steps to 0.
- R3: A write to offset 0x08 makes the count equal the written data from the next cycle on, even if a tick arrives in the same cycle. Reading 0x08 returns the last value written there.
- R4: When a tick moves the count onto the alarm value, the raw flag (offset 0x14, bit 0) is set. An alarm value below the count fires only after the count wraps.
- R5: A write to 0x04 or 0x08 that leaves the alarm value equal to the count sets the raw flag in that same cycle, with no tick needed.
- R6: Only bit 0 of a write to 0x10 is kept. The interrupt pin and the read of 0x18 both equal the raw flag AND that bit.
- R7: Any write to 0x1C clears the raw flag, whatever the data. If a set event happens in the same cycle, the flag stays set.
- R8: Offset 0x0C always reads 1. Writes to 0x0C, 0x00, 0x14 and 0x18, to unaligned addresses, and to unmapped addresses change no readable state.
- R9: Word offsets 0xFE0 through 0xFFC return, in bits 7:0 with the upper bits zero, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in address order.
- R10: Reads of 0x1C, of unaligned addresses and of any unmapped offset return 0.
- R11: While the count stays equal to the alarm value, a set flag that has been cleared is not set again. It is set again only by a new tick or by a write of the alarm value or the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| bus_sel | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address within the block |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data |
| alarm_irq | output | 1 | Level interrupt: raw flag AND mask |

## Verification
The bench targets the wrap from 0xFFFFFFFF to 0 onto an alarm value of 0. A compare that was not modulo would never fire there. It tests a preset or alarm write that lands exactly on the count: an edge-only design would miss that alarm. It drives a clear in the same cycle as a tick that reaches the alarm. Wrong priority there would lose the alarm, and a level compare would refire after every clear. Writes to read-only, control and unaligned locations are followed by reads. A decoder that aliased them would corrupt the count or the flag.

// File: rtl/rtc_alarm_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_pkg;

   localparam int unsigned WIN_BITS = 12;
   localparam int unsigned IDX_BITS = WIN_BITS - 2;
   localparam int unsigned ID_DEPTH = 8;
   localparam int unsigned ID_SEL_W = $clog2(ID_DEPTH);

   localparam logic [IDX_BITS-1:0] IX_COUNT   = 10'h000;
   localparam logic [IDX_BITS-1:0] IX_ALARM   = 10'h001;
   localparam logic [IDX_BITS-1:0] IX_PRESET  = 10'h002;
   localparam logic [IDX_BITS-1:0] IX_CTRL    = 10'h003;
   localparam logic [IDX_BITS-1:0] IX_MASK    = 10'h004;
   localparam logic [IDX_BITS-1:0] IX_RAW     = 10'h005;
   localparam logic [IDX_BITS-1:0] IX_MASKED  = 10'h006;
   localparam logic [IDX_BITS-1:0] IX_CLEAR   = 10'h007;
   localparam logic [IDX_BITS-1:0] IX_ID_BASE = 10'h3F8;

   typedef enum logic [3:0] {
      SRC_ZERO,
      SRC_COUNT,
      SRC_ALARM,
      SRC_PRESET,
      SRC_CTRL,
      SRC_MASK,
      SRC_RAW,
      SRC_MASKED,
      SRC_ID
   } rd_src_e;

   typedef struct packed {
      logic preset;
      logic alarm;
      logic mask;
      logic clear;
   } wr_strobe_t;

   function automatic logic [7:0] id_byte(input int unsigned slot);
      logic [7:0] b;
      case (slot)
         0:       b = 8'h31;
         1:       b = 8'h10;
         2:       b = 8'h14;
         3:       b = 8'h00;
         4:       b = 8'h0D;
         5:       b = 8'hF0;
         6:       b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/rtc_bus_decode.sv
`timescale 1ns/1ps
module rtc_bus_decode
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic                bus_sel,
   input  logic                bus_write,
   input  logic [ADDR_W-1:0]   bus_addr,
   output wr_strobe_t          wr_stb,
   output rd_src_e             rd_src,
   output logic [ID_SEL_W-1:0] id_sel
);

   logic                upper_ok;
   logic                hit;
   logic                wr_hit;
   logic                rd_hit;
   logic [IDX_BITS-1:0] idx;

   if (ADDR_W < WIN_BITS) begin : g_addr_chk
      $error("rtc_bus_decode: ADDR_W must cover a 4 KB window");
   end

   if (ADDR_W > WIN_BITS) begin : g_wide
      assign upper_ok = (bus_addr[ADDR_W-1:WIN_BITS] == '0);
   end else begin : g_exact
      assign upper_ok = 1'b1;
   end

   assign idx    = bus_addr[WIN_BITS-1:2];
   assign hit    = upper_ok && (bus_addr[1:0] == 2'b00);
   assign wr_hit = bus_sel &&  bus_write && hit;
   assign rd_hit = bus_sel && !bus_write && hit;
   assign id_sel = idx[ID_SEL_W-1:0];

   always_comb begin
      wr_stb        = '0;
      wr_stb.preset = wr_hit && (idx == IX_PRESET);
      wr_stb.alarm  = wr_hit && (idx == IX_ALARM);
      wr_stb.mask   = wr_hit && (idx == IX_MASK);
      wr_stb.clear  = wr_hit && (idx == IX_CLEAR);
   end

   always_comb begin
      rd_src = SRC_ZERO;
      if (rd_hit) begin
         if (idx >= IX_ID_BASE) begin
            rd_src = SRC_ID;
         end else begin
            case (idx)
               IX_COUNT:  rd_src = SRC_COUNT;
               IX_ALARM:  rd_src = SRC_ALARM;
               IX_PRESET: rd_src = SRC_PRESET;
               IX_CTRL:   rd_src = SRC_CTRL;
               IX_MASK:   rd_src = SRC_MASK;
               IX_RAW:    rd_src = SRC_RAW;
               IX_MASKED: rd_src = SRC_MASKED;
               default:   rd_src = SRC_ZERO;
            endcase
         end
      end
   end

endmodule

// File: rtl/rtc_sec_counter.sv
`timescale 1ns/1ps
module rtc_sec_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             preset_wr,
   input  logic [CNT_W-1:0] preset_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic [CNT_W-1:0] preset_q,
   output logic             cnt_moved
);

   if (CNT_W < 8) begin : g_width_chk
      $error("rtc_sec_counter: CNT_W must be at least 8");
   end

   always_comb begin
      if (preset_wr) begin
         cnt_nxt = preset_val;
      end else if (tick) begin
         cnt_nxt = cnt_q + CNT_W'(1);
      end else begin
         cnt_nxt = cnt_q;
      end
   end

   assign cnt_moved = tick | preset_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         preset_q <= '0;
      end else begin
         cnt_q <= cnt_nxt;
         if (preset_wr) begin
            preset_q <= preset_val;
         end
      end
   end

endmodule

// File: rtl/rtc_alarm_status.sv
`timescale 1ns/1ps
module rtc_alarm_status #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             cnt_moved,
   input  logic             alarm_wr,
   input  logic             mask_wr,
   input  logic             clear_wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] alarm_q,
   output logic             mask_q,
   output logic             raw_q,
   output logic             irq
);

   logic [CNT_W-1:0] alarm_nxt;
   logic             set_evt;
   logic             raw_d;

   assign alarm_nxt = alarm_wr ? wdata : alarm_q;
   assign set_evt   = (cnt_moved || alarm_wr) && (cnt_nxt == alarm_nxt);

   always_comb begin
      raw_d = raw_q;
      if (set_evt) begin
         raw_d = 1'b1;
      end else if (clear_wr) begin
         raw_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_q <= '0;
         mask_q  <= 1'b0;
         raw_q   <= 1'b0;
      end else begin
         alarm_q <= alarm_nxt;
         raw_q   <= raw_d;
         if (mask_wr) begin
            mask_q <= wdata[0];
         end
      end
   end

   assign irq = raw_q & mask_q;

endmodule

// File: rtl/rtc_id_rom.sv
`timescale 1ns/1ps
module rtc_id_rom
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = ID_DEPTH
) (
   input  logic [ID_SEL_W-1:0] sel,
   output logic [DATA_W-1:0]   word
);

   logic [7:0] table_q [DEPTH];

   if (DEPTH != ID_DEPTH) begin : g_depth_chk
      $error("rtc_id_rom: DEPTH must match the identification window");
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign table_q[g] = id_byte(g);
   end

   assign word = DATA_W'(table_q[sel]);

endmodule

// File: rtl/rtc_alarm_top.sv
`timescale 1ns/1ps
module rtc_alarm_top
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              bus_sel,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              alarm_irq
);

   if (DATA_W < 8) begin : g_data_chk
      $error("rtc_alarm_top: DATA_W must hold an identification byte");
   end

   wr_strobe_t          wr_stb;
   rd_src_e             rd_src;
   logic [ID_SEL_W-1:0] id_sel;
   logic [DATA_W-1:0]   cnt_q;
   logic [DATA_W-1:0]   cnt_nxt;
   logic [DATA_W-1:0]   preset_q;
   logic                cnt_moved;
   logic [DATA_W-1:0]   alarm_q;
   logic                mask_q;
   logic                raw_q;
   logic [DATA_W-1:0]   id_word;

   rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_sel   (bus_sel),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .wr_stb    (wr_stb),
      .rd_src    (rd_src),
      .id_sel    (id_sel)
   );

   rtc_sec_counter #(.CNT_W(DATA_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (sec_tick),
      .preset_wr  (wr_stb.preset),
      .preset_val (bus_wdata),
      .cnt_q      (cnt_q),
      .cnt_nxt    (cnt_nxt),
      .preset_q   (preset_q),
      .cnt_moved  (cnt_moved)
   );

   rtc_alarm_status #(.CNT_W(DATA_W)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_nxt   (cnt_nxt),
      .cnt_moved (cnt_moved),
      .alarm_wr  (wr_stb.alarm),
      .mask_wr   (wr_stb.mask),
      .clear_wr  (wr_stb.clear),
      .wdata     (bus_wdata),
      .alarm_q   (alarm_q),
      .mask_q    (mask_q),
      .raw_q     (raw_q),
      .irq       (alarm_irq)
   );

   rtc_id_rom #(.DATA_W(DATA_W)) u_id (
      .sel  (id_sel),
      .word (id_word)
   );

   always_comb begin
      case (rd_src)
         SRC_COUNT:  bus_rdata = cnt_q;
         SRC_ALARM:  bus_rdata = alarm_q;
         SRC_PRESET: bus_rdata = preset_q;
         SRC_CTRL:   bus_rdata = DATA_W'(1);
         SRC_MASK:   bus_rdata = DATA_W'(mask_q);
         SRC_RAW:    bus_rdata = DATA_W'(raw_q);
         SRC_MASKED: bus_rdata = DATA_W'(raw_q & mask_q);
         SRC_ID:     bus_rdata = id_word;
         default:    bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/rtc_alarm_chk.sv
`timescale 1ns/1ps
module rtc_alarm_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_tick,
   input logic              bus_sel,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              alarm_irq,
   input logic [DATA_W-1:0] cnt,
   input logic              raw
);

   localparam logic [ADDR_W-1:0] A_ALARM  = ADDR_W'('h004);
   localparam logic [ADDR_W-1:0] A_PRESET = ADDR_W'('h008);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'('h00C);
   localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'('h01C);

   logic wr;
   logic rd;
   assign wr = bus_sel &&  bus_write;
   assign rd = bus_sel && !bus_write;

   // R3
   preset_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == A_PRESET) |=> (cnt == $past(bus_wdata)));

   // R2
   tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !(wr && bus_addr == A_PRESET)) |=> (cnt == DATA_W'($past(cnt) + 1'b1)));

   // R7
   clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == A_CLEAR && !sec_tick) |=> !raw);

   // R4 R5 R11
   raw_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw) |-> $past(sec_tick || (wr && (bus_addr == A_PRESET || bus_addr == A_ALARM))));

   // R6
   irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> raw);

   // R8
   ctrl_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == A_CTRL) |-> (bus_rdata == DATA_W'(1)));

   // R10
   clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == A_CLEAR) |-> (bus_rdata == '0));

endmodule

bind rtc_alarm_top rtc_alarm_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sec_tick  (sec_tick),
   .bus_sel   (bus_sel),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .alarm_irq (alarm_irq),
   .cnt       (cnt_q),
   .raw       (raw_q)
);

// File: tb/rtc_alarm_top_test.sv
`timescale 1ns/1ps
module rtc_alarm_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        alarm_irq;

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;

   logic [31:0] m_cnt, m_alarm, m_preset;
   logic        m_mask, m_raw;

   always #10 clk = ~clk;

   rtc_alarm_top uut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_sel(bus_sel),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
   );

   function automatic logic [7:0] exp_id(input int unsigned k);
      logic [7:0] t [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      return t[k];
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      if (a[1:0] != 2'b00) return 32'h0;
      if (a >= 12'hFE0) return {24'h0, exp_id(int'(a[4:2]))};
      case (a)
         12'h000: return m_cnt;
         12'h004: return m_alarm;
         12'h008: return m_preset;
         12'h00C: return 32'h1;
         12'h010: return {31'h0, m_mask};
         12'h014: return {31'h0, m_raw};
         12'h018: return {31'h0, m_raw & m_mask};
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_step(input logic tk, input logic wr, input logic [11:0] a,
                             input logic [31:0] d);
      logic wp, wa, wm, wc, setv;
      logic [31:0] nc, na;
      wp = wr && a == 12'h008;
      wa = wr && a == 12'h004;
      wm = wr && a == 12'h010;
      wc = wr && a == 12'h01C;
      nc = wp ? d : (tk ? m_cnt + 32'd1 : m_cnt);
      na = wa ? d : m_alarm;
      setv = (tk || wp || wa) && (nc == na);
      m_cnt = nc;
      m_alarm = na;
      if (wp) m_preset = d;
      if (wm) m_mask = d[0];
      if (setv) m_raw = 1'b1;
      else if (wc) m_raw = 1'b0;
   endtask

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic tk, input logic wr, input logic [11:0] a,
                       input logic [31:0] d);
      @(negedge clk);
      sec_tick = tk; bus_sel = wr; bus_write = wr; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      model_step(tk, wr, a, d);
      #1;
      sec_tick = 1'b0; bus_sel = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input string tag);
      logic [31:0] e;
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
      #2;
      e = exp_read(a);
      check(bus_rdata == e, tag, bus_rdata, e);
      check(alarm_irq == (m_raw & m_mask), {tag, " irq"}, {31'h0, alarm_irq},
            {31'h0, m_raw & m_mask});
      @(posedge clk);
      #1 bus_sel = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [11:0] addrs [12] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
                                  12'h018, 12'h01C, 12'h020, 12'h00A, 12'hFE4, 12'hFFC};
      void'($urandom(32'd4242));
      m_cnt = '0; m_alarm = '0; m_preset = '0; m_mask = 1'b0; m_raw = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd_chk(12'h000, "R1 count");
      rd_chk(12'h004, "R1 alarm");
      rd_chk(12'h008, "R1 preset");
      rd_chk(12'h010, "R1 mask");
      rd_chk(12'h014, "R1 raw");
      rd_chk(12'h018, "R1 masked");

      // R3 preset, R2 and R4 wrap onto alarm 0
      step(1'b0, 1'b1, 12'h008, 32'hFFFF_FFFE);
      rd_chk(12'h000, "R3 preset count");
      rd_chk(12'h008, "R3 preset readback");
      step(1'b1, 1'b0, 12'h000, 32'h0);
      rd_chk(12'h014, "R4 no early alarm");
      step(1'b1, 1'b0, 12'h000, 32'h0);
      rd_chk(12'h000, "R2 wrap to zero");
      rd_chk(12'h014, "R4 alarm after wrap");

      // R6 mask only bit 0
      step(1'b0, 1'b1, 12'h010, 32'hFFFF_FFFE);
      rd_chk(12'h010, "R6 mask bit0 only");
      rd_chk(12'h018, "R6 masked off");
      step(1'b0, 1'b1, 12'h010, 32'h0000_0003);
      rd_chk(12'h018, "R6 masked on");

      // R7 clear with zero data; R11 no refire while still equal
      step(1'b0, 1'b1, 12'h01C, 32'h0);
      rd_chk(12'h014, "R7 clear any data");
      step(1'b0, 1'b0, 12'h000, 32'h0);
      rd_chk(12'h014, "R11 no refire");

      // R5 immediate set on alarm write and on preset write
      step(1'b0, 1'b1, 12'h004, 32'h0);
      rd_chk(12'h014, "R5 alarm write equal");
      step(1'b0, 1'b1, 12'h01C, 32'h1);
      step(1'b0, 1'b1, 12'h004, 32'd5);
      rd_chk(12'h014, "R5 alarm write unequal");
      step(1'b0, 1'b1, 12'h008, 32'd5);
      rd_chk(12'h014, "R5 preset write equal");
      step(1'b0, 1'b1, 12'h01C, 32'h0);

      // R3 preset beats tick
      step(1'b1, 1'b1, 12'h008, 32'd100);
      rd_chk(12'h000, "R3 preset over tick");

      // R7 set wins over clear
      step(1'b0, 1'b1, 12'h004, 32'd101);
      step(1'b1, 1'b1, 12'h01C, 32'h0);
      rd_chk(12'h014, "R7 set beats clear");

      // R8 ignored writes
      step(1'b0, 1'b1, 12'h000, 32'h55);
      step(1'b0, 1'b1, 12'h014, 32'h0);
      step(1'b0, 1'b1, 12'h018, 32'h0);
      step(1'b0, 1'b1, 12'h00C, 32'h0);
      step(1'b0, 1'b1, 12'h040, 32'h1);
      step(1'b0, 1'b1, 12'h00A, 32'h7);
      step(1'b0, 1'b1, 12'h01E, 32'h7);
      rd_chk(12'h000, "R8 count kept");
      rd_chk(12'h008, "R8 preset kept");
      rd_chk(12'h014, "R8 raw kept");
      rd_chk(12'h00C, "R8 control one");

      // R9 id window, R10 zero reads
      for (int k = 0; k < 8; k++) rd_chk(12'hFE0 + 12'(4 * k), "R9 id byte");
      rd_chk(12'h01C, "R10 clear reads zero");
      rd_chk(12'h020, "R10 unmapped");
      rd_chk(12'hFDC, "R10 below id");
      rd_chk(12'h00A, "R10 unaligned");

      // random mix
      for (int i = 0; i < 600; i++) begin
         int unsigned op;
         logic [11:0] a;
         logic [31:0] d;
         op = $urandom % 5;
         a = addrs[$urandom % 12];
         d = (a == 12'h004 || a == 12'h008) ? m_cnt + ($urandom % 4) : $urandom;
         case (op)
            0: step(1'b1, 1'b0, 12'h000, 32'h0);
            1: step(1'b0, 1'b1, a, d);
            2: step(1'b1, 1'b1, a, d);
            default: rd_chk(a, "R4 R5 R7 random");
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule